// File: doc/BRIEF.md
# Scaler Source-Position Stepper

This block drives the source-side addressing of a video scaler. Each output pixel and each output line moves a fixed-point source position forward by a programmed ratio. For each axis the block presents the integer source index, a 15-bit interpolation phase, and a one-clock flag. The flag tells the input side that the integer index has moved, so the next source pixel or line must be consumed. The filter arithmetic and the line storage are outside this block.

The ratios are unsigned 1.15 fixed-point numbers: input resolution over output resolution, times 32768, so 0x8000 is unity. Values below 0x8000 expand and values above it shrink. A third register holds a line period in sixteenths of an input clock. From it the block derives a virtual line-start pulse in the input clock domain, and the fractional remainder is carried forward so that the pulse rate does not drift. All three values are written a byte at a time into holding registers, and the working copies are loaded only at frame start.

Top module: `scale_step_engine`

## Requirements
- R1: After reset, both working ratios are 0x8000 and the working period is 0x5400 (1344 clocks). Both indices, both phases and both flags read 0, and `emu_line` is 0. With no frame start, the first `emu_line` pulse appears after the 1344th clock edge following reset release.
- R2: A write with `cfg_wr` high stores `cfg_wdata` into one byte of a holding register, chosen by `cfg_sel`. The codes are: 0 for the horizontal ratio low byte, 1 for its high byte, 2 and 3 for the vertical ratio, 4 and 5 for the period. Codes 6 and 7 write nothing. Holding values reach the working copies only on a `frame_start` cycle.
- R3: A `pix_step` cycle without a clear adds the horizontal ratio to a position of H_IDX_W+15 bits. After that edge, `h_index` shows the position bits above bit 14 and `h_phase` shows bits [14:0]. With no step and no clear, both hold.
- R4: `line_start` or `frame_start` clears the horizontal position to 0 and takes priority over a `pix_step` in the same cycle.
- R5: `h_adv` and `v_adv` are high for exactly the clock after a step that changed the integer index, and are low after idle cycles and clears.
- R6: `frame_start` clears the vertical position. A `line_start` without `frame_start` adds the vertical ratio to it, with the same index, phase and flag layout as R3 (H replaced by V). With neither signal high, the vertical outputs hold.
- R7: Both positions wrap modulo 2^(IDX_W+15), so the indices wrap modulo 2^IDX_W.
- R8: For a working period P ≥ 16, an internal count adds 16 on every clock. When the sum reaches P, `emu_line` pulses on the next clock and the count keeps the sum minus P. After k clocks from a frame start, the pulse count is floor(16k/P). `frame_start` clears the count and the pulse.
- R9: A working period below 16, including 0, makes `emu_line` high on every clock that does not follow a `frame_start`.
- R10: A write in the same cycle as `frame_start` goes only into the holding register. It reaches the working copy at the next frame start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Byte write strobe |
| cfg_sel | input | 3 | Byte select (see R2) |
| cfg_wdata | input | 8 | Write byte |
| frame_start | input | 1 | Output frame start: loads working values, clears both positions and the period count |
| line_start | input | 1 | Output line start: clears horizontal, steps vertical |
| pix_step | input | 1 | Output pixel step |
| h_index | output | H_IDX_W | Horizontal source index |
| h_phase | output | 15 | Horizontal interpolation phase |
| h_adv | output | 1 | Horizontal source advance flag |
| v_index | output | V_IDX_W | Vertical source index |
| v_phase | output | 15 | Vertical interpolation phase |
| v_adv | output | 1 | Vertical source line advance flag |
| emu_line | output | 1 | Virtual line-start pulse |

## Verification
Every position result is registered once. Index, phase and flag therefore reflect a step or clear at the clock edge that consumes it. The bench drives each control on a falling edge and reads the outputs at the next falling edge, which is exactly one edge later. A byte write changes nothing visible until a later frame start. Its effect appears in the first step after that frame start, so the bench checks that step and the steps that follow. The period pulse is registered after the comparison, so the pulse for the k-th clock edge after a frame start is read right after that edge and compared with floor(16k/P) − floor(16(k−1)/P).

// File: rtl/scl_pkg.sv
package scl_pkg;
  localparam int FRAC_W   = 15;
  localparam int RATIO_W  = 16;
  localparam int PERIOD_W = 16;
  localparam int EMU_W    = PERIOD_W + 1;
  localparam int EMU_STEP = 16;
  localparam int NUM_CFG  = 3;

  localparam logic [RATIO_W-1:0]  RATIO_UNITY  = 16'h8000;
  localparam logic [PERIOD_W-1:0] PERIOD_RESET = 16'h5400;

  typedef struct packed {
    logic             fire;
    logic [EMU_W-1:0] cnt;
  } emu_res_t;

  // reset value of configuration slot g (0: h ratio, 1: v ratio, 2: period)
  function automatic logic [15:0] cfg_reset(input int g);
    return (g == 2) ? PERIOD_RESET : RATIO_UNITY;
  endfunction

  // replace one byte lane of a 16-bit holding value
  function automatic logic [15:0] put_byte(input logic [15:0] old, input logic hi,
                                           input logic [7:0] data);
    return hi ? {data, old[7:0]} : {old[15:8], data};
  endfunction

  // one clock of the line-period emulation counter
  function automatic emu_res_t emu_next(input logic [EMU_W-1:0] cnt,
                                        input logic [PERIOD_W-1:0] per);
    emu_res_t         r;
    logic [EMU_W-1:0] sum;
    sum = cnt + EMU_W'(EMU_STEP);
    if (per < PERIOD_W'(EMU_STEP)) begin
      r.fire = 1'b1;
      r.cnt  = '0;
    end else if (sum >= EMU_W'(per)) begin
      r.fire = 1'b1;
      r.cnt  = sum - EMU_W'(per);
    end else begin
      r.fire = 1'b0;
      r.cnt  = sum;
    end
    return r;
  endfunction
endpackage

// File: rtl/scl_cfg_regs.sv
module scl_cfg_regs
  import scl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [2:0]          wr_sel,
  input  logic [7:0]          wr_data,
  input  logic                latch,
  output logic [RATIO_W-1:0]  hr_act,
  output logic [RATIO_W-1:0]  vr_act,
  output logic [PERIOD_W-1:0] per_act
);
  logic [15:0] act_w [NUM_CFG];

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_slot
    logic [15:0] hold_q;
    logic [15:0] act_q;
    logic        hit;

    assign hit = wr_en && (wr_sel[2:1] == 2'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hold_q <= cfg_reset(g);
        act_q  <= cfg_reset(g);
      end else begin
        if (hit) hold_q <= put_byte(hold_q, wr_sel[0], wr_data);
        if (latch) act_q <= hold_q;
      end
    end

    assign act_w[g] = act_q;
  end

  assign hr_act  = act_w[0];
  assign vr_act  = act_w[1];
  assign per_act = act_w[2];
endmodule

// File: rtl/scl_pos_acc.sv
module scl_pos_acc
  import scl_pkg::*;
#(
  parameter int IDX_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  input  logic [RATIO_W-1:0] ratio,
  output logic [IDX_W-1:0]   index,
  output logic [FRAC_W-1:0]  phase,
  output logic               adv
);
  localparam int ACC_W = IDX_W + FRAC_W;

  logic [ACC_W-1:0] pos_q;
  logic [ACC_W-1:0] pos_nxt;
  logic             int_moved;

  assign pos_nxt   = pos_q + ACC_W'(ratio);
  assign int_moved = pos_nxt[ACC_W-1:FRAC_W] != pos_q[ACC_W-1:FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      adv   <= 1'b0;
    end else if (clr) begin
      pos_q <= '0;
      adv   <= 1'b0;
    end else if (step) begin
      pos_q <= pos_nxt;
      adv   <= int_moved;
    end else begin
      adv   <= 1'b0;
    end
  end

  assign index = pos_q[ACC_W-1:FRAC_W];
  assign phase = pos_q[FRAC_W-1:0];
endmodule

// File: rtl/scl_line_emu.sv
module scl_line_emu
  import scl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic [PERIOD_W-1:0] period,
  output logic                pulse,
  output logic [EMU_W-1:0]    cnt
);
  emu_res_t nxt;

  assign nxt = emu_next(cnt, period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else if (clr) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      cnt   <= nxt.cnt;
      pulse <= nxt.fire;
    end
  end
endmodule

// File: rtl/scale_step_engine.sv
module scale_step_engine
  import scl_pkg::*;
#(
  parameter int H_IDX_W = 12,
  parameter int V_IDX_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [2:0]         cfg_sel,
  input  logic [7:0]         cfg_wdata,
  input  logic               frame_start,
  input  logic               line_start,
  input  logic               pix_step,
  output logic [H_IDX_W-1:0] h_index,
  output logic [FRAC_W-1:0]  h_phase,
  output logic               h_adv,
  output logic [V_IDX_W-1:0] v_index,
  output logic [FRAC_W-1:0]  v_phase,
  output logic               v_adv,
  output logic               emu_line
);
  // named internal events
  logic                h_clr;
  logic                h_step;
  logic                v_clr;
  logic                v_step;
  logic [RATIO_W-1:0]  hr_act;
  logic [RATIO_W-1:0]  vr_act;
  logic [PERIOD_W-1:0] per_act;
  logic [EMU_W-1:0]    emu_cnt;

  assign h_clr  = frame_start | line_start;
  assign h_step = pix_step;
  assign v_clr  = frame_start;
  assign v_step = line_start;

  scl_cfg_regs cfg_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cfg_wr),
    .wr_sel  (cfg_sel),
    .wr_data (cfg_wdata),
    .latch   (frame_start),
    .hr_act  (hr_act),
    .vr_act  (vr_act),
    .per_act (per_act)
  );

  scl_pos_acc #(.IDX_W(H_IDX_W)) h_acc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (h_clr),
    .step  (h_step),
    .ratio (hr_act),
    .index (h_index),
    .phase (h_phase),
    .adv   (h_adv)
  );

  scl_pos_acc #(.IDX_W(V_IDX_W)) v_acc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (v_clr),
    .step  (v_step),
    .ratio (vr_act),
    .index (v_index),
    .phase (v_phase),
    .adv   (v_adv)
  );

  scl_line_emu emu_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (frame_start),
    .period (per_act),
    .pulse  (emu_line),
    .cnt    (emu_cnt)
  );
endmodule

// File: rtl/scale_step_engine_chk.sv
module scale_step_engine_chk #(
  parameter int H_IDX_W = 12,
  parameter int V_IDX_W = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_start,
  input logic               line_start,
  input logic               pix_step,
  input logic [H_IDX_W-1:0] h_index,
  input logic [14:0]        h_phase,
  input logic               h_adv,
  input logic [V_IDX_W-1:0] v_index,
  input logic [14:0]        v_phase,
  input logic               v_adv,
  input logic               emu_line,
  input logic [15:0]        hr_act,
  input logic [15:0]        vr_act,
  input logic [15:0]        per_act,
  input logic [16:0]        emu_cnt
);
  assert_hold_cfg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(hr_act) && $stable(vr_act) && $stable(per_act)));

  assert_h_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start || line_start || pix_step) |=> ($stable(h_index) && $stable(h_phase) && !h_adv));

  assert_h_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start || line_start) |=> (h_index == '0 && h_phase == '0 && !h_adv));

  assert_adv_moves_R5: assert property (@(posedge clk) disable iff (!rst_n)
    h_adv |-> (h_index != $past(h_index)));

  assert_v_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (v_index == '0 && v_phase == '0 && !v_adv));

  assert_v_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start || line_start) |=> ($stable(v_index) && $stable(v_phase) && !v_adv));

  assert_emu_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (!emu_line && emu_cnt == '0));

  assert_emu_remainder_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act >= 16'd16 && !frame_start) |=> (emu_cnt < {1'b0, per_act}));

  assert_emu_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (emu_line && per_act >= 16'd32 && !frame_start) |=> !emu_line);

  assert_emu_short_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (per_act < 16'd16 && !frame_start) |=> emu_line);
endmodule

bind scale_step_engine scale_step_engine_chk #(.H_IDX_W(H_IDX_W), .V_IDX_W(V_IDX_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .line_start  (line_start),
  .pix_step    (pix_step),
  .h_index     (h_index),
  .h_phase     (h_phase),
  .h_adv       (h_adv),
  .v_index     (v_index),
  .v_phase     (v_phase),
  .v_adv       (v_adv),
  .emu_line    (emu_line),
  .hr_act      (hr_act),
  .vr_act      (vr_act),
  .per_act     (per_act),
  .emu_cnt     (emu_cnt)
);

// File: tb/scale_step_engine_tb.sv
module scale_step_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 6;
  localparam int VW = 5;
  localparam longint HMASK = (64'd1 << (HW + 15)) - 1;
  localparam longint VMASK = (64'd1 << (VW + 15)) - 1;
  localparam int WATCHDOG = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_wr = 1'b0;
  logic [2:0]    cfg_sel = '0;
  logic [7:0]    cfg_wdata = '0;
  logic          frame_start = 1'b0;
  logic          line_start = 1'b0;
  logic          pix_step = 1'b0;
  logic [HW-1:0] h_index;
  logic [14:0]   h_phase;
  logic          h_adv;
  logic [VW-1:0] v_index;
  logic [14:0]   v_phase;
  logic          v_adv;
  logic          emu_line;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  scale_step_engine #(.H_IDX_W(HW), .V_IDX_W(VW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .frame_start(frame_start), .line_start(line_start), .pix_step(pix_step),
    .h_index(h_index), .h_phase(h_phase), .h_adv(h_adv),
    .v_index(v_index), .v_phase(v_phase), .v_adv(v_adv), .emu_line(emu_line)
  );

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // one clock: drive at a falling edge, return at the next falling edge
  task automatic cyc(input logic fs, input logic ls, input logic ps,
                     input logic we = 1'b0, input logic [2:0] sel = 3'd0,
                     input logic [7:0] d = 8'd0);
    frame_start = fs; line_start = ls; pix_step = ps;
    cfg_wr = we; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    frame_start = 1'b0; line_start = 1'b0; pix_step = 1'b0;
    cfg_wr = 1'b0; cfg_sel = 3'd0; cfg_wdata = 8'd0;
  endtask

  task automatic wr16(input logic [2:0] base, input logic [15:0] val);
    cyc(0, 0, 0, 1'b1, base, val[7:0]);
    cyc(0, 0, 0, 1'b1, base + 3'd1, val[15:8]);
  endtask

  function automatic longint hpack();
    return (longint'(h_index) << 16) | (longint'(h_phase) << 1) | longint'(h_adv);
  endfunction

  function automatic longint vpack();
    return (longint'(v_index) << 16) | (longint'(v_phase) << 1) | longint'(v_adv);
  endfunction

  // expected packed result after n steps of ratio r, mask m
  function automatic longint expect_pos(input longint n, input longint r, input longint m,
                                        input bit stepped);
    longint p, q, a;
    p = (n * r) & m;
    q = (n > 0) ? (((n - 1) * r) & m) : 0;
    a = (stepped && ((p >> 15) != (q >> 15))) ? 1 : 0;
    return ((p >> 15) << 16) | ((p & 32'h7fff) << 1) | a;
  endfunction

  task automatic run_h(input logic [15:0] ratio, input int n);
    longint ns = 0;
    wr16(3'd0, ratio);
    cyc(1, 0, 0);
    chk("R4 frame clears h", hpack(), 0);
    for (int c = 0; c < n; c++) begin
      bit ps = (c % 4) != 3;
      cyc(0, 0, ps);
      if (ps) ns++;
      chk("R3/R5/R7 h step", hpack(), expect_pos(ns, longint'(ratio), HMASK, ps));
    end
    cyc(0, 1, 1);
    chk("R4 line_start beats pix_step", hpack(), 0);
  endtask

  task automatic run_v(input logic [15:0] ratio, input int lines);
    wr16(3'd2, ratio);
    cyc(1, 1, 0);
    chk("R6 frame clears v", vpack(), 0);
    for (int l = 1; l <= lines; l++) begin
      cyc(0, 0, 1);
      cyc(0, 0, 1);
      chk("R6 v holds during pixels", vpack(), expect_pos(l - 1, longint'(ratio), VMASK, 1'b0));
      cyc(0, 1, 0);
      chk("R6/R5/R7 v step", vpack(), expect_pos(l, longint'(ratio), VMASK, 1'b1));
      chk("R4 line_start clears h", hpack(), 0);
    end
    cyc(1, 0, 0);
    chk("R6 mid-frame clear", vpack(), 0);
  endtask

  task automatic run_emu(input logic [15:0] per, input int n);
    longint p = longint'(per);
    wr16(3'd4, per);
    cyc(1, 0, 0);
    chk("R8 frame clears pulse", longint'(emu_line), 0);
    for (int k = 1; k <= n; k++) begin
      longint e;
      cyc(0, 0, 0);
      if (p < 16) begin
        chk("R9 short period pulses each clock", longint'(emu_line), 1);
      end else begin
        e = ((16 * k) / p != (16 * (k - 1)) / p) ? 1 : 0;
        chk("R8 period pulse pattern", longint'(emu_line), e);
      end
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1-all: actual running after %0d cycles expected finished", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int first;
    repeat (3) @(negedge clk);
    chk("R1 reset h", hpack(), 0);
    chk("R1 reset v", vpack(), 0);
    chk("R1 reset pulse", longint'(emu_line), 0);
    rst_n = 1'b1;

    // R1: default period 0x5400 gives first pulse after 1344 edges
    first = 0;
    for (int k = 1; k <= 1400; k++) begin
      @(negedge clk);
      if (emu_line && first == 0) first = k;
    end
    chk("R1 default period first pulse", first, 1344);

    // R1: default unity ratio, no frame start needed
    cyc(0, 1, 0);
    for (int s = 1; s <= 3; s++) begin
      cyc(0, 0, 1);
      chk("R1 default unity h ratio", hpack(), (longint'(s) << 16) | 1);
    end

    run_h(16'h8000, 150);
    run_h(16'h4000, 120);
    run_h(16'h5555, 120);
    run_h(16'h2AAB, 120);
    run_h(16'hC000, 120);
    run_h(16'hFFFF, 120);
    run_h(16'h0001, 40);
    run_h(16'h0000, 20);

    run_v(16'h8000, 40);
    run_v(16'h6000, 30);
    run_v(16'hB000, 40);

    // R2/R10: held write and write coinciding with frame start
    wr16(3'd0, 16'h8000);
    cyc(1, 0, 0);
    cyc(0, 0, 0, 1'b1, 3'd0, 8'h00);
    cyc(0, 0, 1);
    chk("R2 held write not yet active", hpack(), (longint'(1) << 16) | 1);
    cyc(0, 0, 0, 1'b1, 3'd6, 8'hFF);
    cyc(0, 0, 0, 1'b1, 3'd7, 8'hFF);
    cyc(1, 0, 0, 1'b1, 3'd1, 8'h40);
    for (int s = 1; s <= 3; s++) begin
      cyc(0, 0, 1);
      chk("R10 same-cycle write deferred", hpack(), (longint'(s) << 16) | 1);
    end
    cyc(1, 0, 0);
    cyc(0, 0, 1);
    chk("R10 value active next frame", hpack(), longint'(16'h4000) << 1);
    cyc(0, 0, 1);
    chk("R2 codes 6/7 ignored, ratio 0x4000", hpack(), (longint'(1) << 16) | 1);

    run_emu(16'h0038, 100);
    run_emu(16'h0030, 60);
    run_emu(16'h0015, 60);
    run_emu(16'h0010, 20);
    run_emu(16'h0100, 80);
    run_emu(16'h0005, 10);
    run_emu(16'h0000, 10);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule